// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a 32-bit device virtual address into a physical address. It reads descriptors from a two-level translation table held in memory. A client presents a virtual address, a read/write flag and the table base address. The walker then fetches one first-level descriptor. If that descriptor points to a second-level table, it fetches one second-level descriptor as well. It reports either the physical address together with the size of the mapping, or a fault that names the level that failed and carries the virtual address that failed.

Three mapping sizes are supported. A first-level entry can map a 1 MB section directly, or it can point to a 256-entry second-level table. Each second-level entry maps a 4 KB small page. A 64 KB large page is stored as sixteen identical second-level entries, and because the second-level index comes from virtual address bits [19:12], any of those sixteen copies resolves the large page. Descriptor reads go through a simple memory read port that allows only one read in flight. The walker accepts a new request only when it is idle.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready_o` is 1 and `done_o`, `fault_o` and `mem_req_valid_o` are 0.
- R2: When a request is accepted, the first read goes to `tbl_base_i + va[31:20]*4`.
- R3: If the first-level descriptor has bits [1:0] = 2, the walk completes with `pa_o = {desc[31:20], va[19:0]}`, `size_o` = 3 (1 MB), and exactly one memory read.
- R4: If the first-level descriptor has bits [1:0] = 0 or 3, the walk faults with `fault_level_o` = 0 and `fault_addr_o` = the requested virtual address, and no second read is issued.
- R5: If the first-level descriptor has bits [1:0] = 1, a second read goes to `(desc & 0xFFFFFC00) + va[19:12]*4`.
- R6: If the second-level descriptor has bits [1:0] = 1, the walk completes with `pa_o = {desc[31:16], va[15:0]}` and `size_o` = 2 (64 KB).
- R7: If the second-level descriptor has bit 1 set (bits [1:0] = 2 or 3), the walk completes with `pa_o = {desc[31:12], va[11:0]}` and `size_o` = 1 (4 KB).
- R8: If the second-level descriptor has bits [1:0] = 0, the walk faults with `fault_level_o` = 1 and `fault_addr_o` = the requested virtual address.
- R9: Each walk ends with exactly one single-cycle pulse, on either `done_o` or `fault_o` but never both. `req_ready_o` is low while a walk is in progress, and a request presented during that time is ignored.
- R10: The table base is captured when the request is accepted. Changing `tbl_base_i` later has no effect on the walk in progress.
- R11: `resp_write_o` returns the `req_write_i` value that was captured when the request was accepted.
- R12: `mem_req_valid_o` is a one-cycle pulse, and at most one read is outstanding at a time. A response that arrives while no read is outstanding is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| req_valid_i | input | 1 | Translation request |
| req_va_i | input | 32 | Virtual address to translate |
| req_write_i | input | 1 | Access is a write (1) or a read (0) |
| tbl_base_i | input | 32 | First-level table base address |
| req_ready_o | output | 1 | Walker is idle and can accept a request |
| mem_req_valid_o | output | 1 | Descriptor read request (one-cycle pulse) |
| mem_req_addr_o | output | 32 | Descriptor read address |
| mem_rsp_valid_i | input | 1 | Read data is valid |
| mem_rsp_data_i | input | 32 | Descriptor word that was read |
| done_o | output | 1 | Translation completed (one-cycle pulse) |
| pa_o | output | 32 | Physical address |
| size_o | output | 2 | Mapping size: 1 = 4 KB, 2 = 64 KB, 3 = 1 MB |
| resp_write_o | output | 1 | Read/write flag captured with the request |
| fault_o | output | 1 | Translation fault (one-cycle pulse) |
| fault_level_o | output | 1 | Level that faulted: 0 = first, 1 = second |
| fault_addr_o | output | 32 | Virtual address that faulted |

## Verification
The bench builds the walker with its default parameters: a 32-bit address, a 1 MB section split at bit 20, a 64 KB large page split at bit 16, a 4 KB page split at bit 12, and second-level tables aligned to 1 KB. These values make every descriptor type reachable from a small sparse memory model.

Memory latency varies from one to five cycles. The longer latencies leave room to change the table base and to present a competing request while a walk is in progress. The test descriptors have garbage in their low control bits, so the bench can check that the second-level base is masked correctly. Both fault levels are covered, as is a response injected while the walker is idle.

// File: rtl/pt_walker_pkg.sv
package pt_walker_pkg;

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_FETCH_L1,
    ST_FETCH_L2,
    ST_DONE,
    ST_FAULT
  } walk_state_e;

  typedef enum logic [1:0] {
    MAP_NONE    = 2'd0,
    MAP_SMALL   = 2'd1,
    MAP_LARGE   = 2'd2,
    MAP_SECTION = 2'd3
  } map_size_e;

  typedef enum logic [1:0] {
    L1_FAULT,
    L1_SECTION,
    L1_TABLE
  } l1_kind_e;

  typedef enum logic [1:0] {
    L2_FAULT,
    L2_LARGE,
    L2_SMALL
  } l2_kind_e;

  localparam logic [1:0] L1_TAG_SECTION = 2'b10;
  localparam logic [1:0] L1_TAG_TABLE   = 2'b01;
  localparam logic [1:0] L2_TAG_LARGE   = 2'b01;

endpackage

// File: rtl/pt_l1_decode.sv
module pt_l1_decode
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W     = 32,
  parameter int SECT_SHIFT = 20,
  parameter int PAGE_SHIFT = 12,
  parameter int L2_ALIGN   = 10
) (
  input  logic [ADDR_W-1:0]     desc_i,
  input  logic [SECT_SHIFT-1:0] va_low_i,
  output l1_kind_e              kind_o,
  output logic [ADDR_W-1:0]     sect_pa_o,
  output logic [ADDR_W-1:0]     l2_addr_o
);

  localparam int L2_IDX_W = SECT_SHIFT - PAGE_SHIFT;

  logic [ADDR_W-1:0]   l2_base;
  logic [ADDR_W-1:0]   l2_off;
  logic [L2_IDX_W-1:0] l2_idx;
  logic                unused_bits;

  assign unused_bits = ^desc_i[L2_ALIGN-1:2];

  assign l2_idx    = va_low_i[SECT_SHIFT-1:PAGE_SHIFT];
  assign l2_base   = {desc_i[ADDR_W-1:L2_ALIGN], {L2_ALIGN{1'b0}}};
  assign l2_off    = ADDR_W'({l2_idx, 2'b00});
  assign l2_addr_o = l2_base + l2_off;
  assign sect_pa_o = {desc_i[ADDR_W-1:SECT_SHIFT], va_low_i};

  always_comb begin
    unique case (desc_i[1:0])
      L1_TAG_SECTION: kind_o = L1_SECTION;
      L1_TAG_TABLE:   kind_o = L1_TABLE;
      default:        kind_o = L1_FAULT;
    endcase
  end

endmodule

// File: rtl/pt_l2_decode.sv
module pt_l2_decode
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int LARGE_SHIFT = 16,
  parameter int PAGE_SHIFT  = 12
) (
  input  logic [ADDR_W-1:0]      desc_i,
  input  logic [LARGE_SHIFT-1:0] va_low_i,
  output l2_kind_e               kind_o,
  output logic [ADDR_W-1:0]      pa_o
);

  logic unused_bits;
  assign unused_bits = ^desc_i[PAGE_SHIFT-1:2];

  always_comb begin
    if (desc_i[1]) begin
      kind_o = L2_SMALL;
    end else if (desc_i[1:0] == L2_TAG_LARGE) begin
      kind_o = L2_LARGE;
    end else begin
      kind_o = L2_FAULT;
    end
  end

  always_comb begin
    if (kind_o == L2_LARGE) begin
      pa_o = {desc_i[ADDR_W-1:LARGE_SHIFT], va_low_i};
    end else begin
      pa_o = {desc_i[ADDR_W-1:PAGE_SHIFT], va_low_i[PAGE_SHIFT-1:0]};
    end
  end

endmodule

// File: rtl/pt_walker.sv
module pt_walker
  import pt_walker_pkg::*;
#(
  parameter int ADDR_W      = 32,
  parameter int SECT_SHIFT  = 20,
  parameter int LARGE_SHIFT = 16,
  parameter int PAGE_SHIFT  = 12,
  parameter int L2_ALIGN    = 10
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              req_valid_i,
  input  logic [ADDR_W-1:0] req_va_i,
  input  logic              req_write_i,
  input  logic [ADDR_W-1:0] tbl_base_i,
  output logic              req_ready_o,
  output logic              mem_req_valid_o,
  output logic [ADDR_W-1:0] mem_req_addr_o,
  input  logic              mem_rsp_valid_i,
  input  logic [ADDR_W-1:0] mem_rsp_data_i,
  output logic              done_o,
  output logic [ADDR_W-1:0] pa_o,
  output logic [1:0]        size_o,
  output logic              resp_write_o,
  output logic              fault_o,
  output logic              fault_level_o,
  output logic [ADDR_W-1:0] fault_addr_o
);

  localparam int L1_IDX_W = ADDR_W - SECT_SHIFT;

  walk_state_e       state_q;
  logic [ADDR_W-1:0] va_q;
  logic              wr_q;
  logic              mem_vld_q;
  logic [ADDR_W-1:0] mem_addr_q;
  logic [ADDR_W-1:0] pa_q;
  map_size_e         size_q;
  logic              flvl_q;

  logic              accept;
  logic              rsp_take;
  logic [L1_IDX_W-1:0] l1_idx;
  logic [ADDR_W-1:0] l1_addr;

  l1_kind_e          l1_kind;
  logic [ADDR_W-1:0] l1_sect_pa;
  logic [ADDR_W-1:0] l1_next_addr;
  l2_kind_e          l2_kind;
  logic [ADDR_W-1:0] l2_pa;

  assign accept   = (state_q == ST_IDLE) && req_valid_i;
  // A response is only meaningful after the request pulse has gone out
  assign rsp_take = mem_rsp_valid_i && !mem_vld_q;
  assign l1_idx   = req_va_i[ADDR_W-1:SECT_SHIFT];
  // The base only feeds this sum, so capturing the address captures the base
  assign l1_addr  = tbl_base_i + ADDR_W'({l1_idx, 2'b00});

  pt_l1_decode #(
    .ADDR_W    (ADDR_W),
    .SECT_SHIFT(SECT_SHIFT),
    .PAGE_SHIFT(PAGE_SHIFT),
    .L2_ALIGN  (L2_ALIGN)
  ) u_l1_dec (
    .desc_i   (mem_rsp_data_i),
    .va_low_i (va_q[SECT_SHIFT-1:0]),
    .kind_o   (l1_kind),
    .sect_pa_o(l1_sect_pa),
    .l2_addr_o(l1_next_addr)
  );

  pt_l2_decode #(
    .ADDR_W     (ADDR_W),
    .LARGE_SHIFT(LARGE_SHIFT),
    .PAGE_SHIFT (PAGE_SHIFT)
  ) u_l2_dec (
    .desc_i  (mem_rsp_data_i),
    .va_low_i(va_q[LARGE_SHIFT-1:0]),
    .kind_o  (l2_kind),
    .pa_o    (l2_pa)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q    <= ST_IDLE;
      va_q       <= '0;
      wr_q       <= 1'b0;
      mem_vld_q  <= 1'b0;
      mem_addr_q <= '0;
      pa_q       <= '0;
      size_q     <= MAP_NONE;
      flvl_q     <= 1'b0;
    end else begin
      unique case (state_q)
        ST_IDLE: begin
          if (accept) begin
            va_q       <= req_va_i;
            wr_q       <= req_write_i;
            mem_addr_q <= l1_addr;
            mem_vld_q  <= 1'b1;
            size_q     <= MAP_NONE;
            state_q    <= ST_FETCH_L1;
          end
        end
        ST_FETCH_L1: begin
          mem_vld_q <= 1'b0;
          if (rsp_take) begin
            unique case (l1_kind)
              L1_SECTION: begin
                pa_q    <= l1_sect_pa;
                size_q  <= MAP_SECTION;
                state_q <= ST_DONE;
              end
              L1_TABLE: begin
                mem_addr_q <= l1_next_addr;
                mem_vld_q  <= 1'b1;
                state_q    <= ST_FETCH_L2;
              end
              default: begin
                flvl_q  <= 1'b0;
                state_q <= ST_FAULT;
              end
            endcase
          end
        end
        ST_FETCH_L2: begin
          mem_vld_q <= 1'b0;
          if (rsp_take) begin
            unique case (l2_kind)
              L2_LARGE: begin
                pa_q    <= l2_pa;
                size_q  <= MAP_LARGE;
                state_q <= ST_DONE;
              end
              L2_SMALL: begin
                pa_q    <= l2_pa;
                size_q  <= MAP_SMALL;
                state_q <= ST_DONE;
              end
              default: begin
                flvl_q  <= 1'b1;
                state_q <= ST_FAULT;
              end
            endcase
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign req_ready_o     = (state_q == ST_IDLE);
  assign mem_req_valid_o = mem_vld_q;
  assign mem_req_addr_o  = mem_addr_q;
  assign done_o          = (state_q == ST_DONE);
  assign fault_o         = (state_q == ST_FAULT);
  assign pa_o            = pa_q;
  assign size_o          = size_q;
  assign resp_write_o    = wr_q;
  assign fault_level_o   = flvl_q;
  assign fault_addr_o    = va_q;

  p_accept_fetch_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_i && req_ready_o) |=> mem_req_valid_o);

  p_req_pulse_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |=> !mem_req_valid_o);

  p_busy_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_valid_o |-> !req_ready_o);

  p_done_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |=> !done_o);

  p_fault_pulse_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    fault_o |=> !fault_o);

  p_excl_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_o |-> !fault_o);

  p_sect_off_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && size_o == MAP_SECTION) |->
      pa_o[SECT_SHIFT-1:0] == fault_addr_o[SECT_SHIFT-1:0]);

  p_large_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && size_o == MAP_LARGE) |->
      pa_o[LARGE_SHIFT-1:0] == fault_addr_o[LARGE_SHIFT-1:0]);

  p_small_off_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (done_o && size_o == MAP_SMALL) |->
      pa_o[PAGE_SHIFT-1:0] == fault_addr_o[PAGE_SHIFT-1:0]);

endmodule

// File: tb/pt_walker_test.sv
module pt_walker_test;

  logic        clk = 1'b0;
  always #4 clk = ~clk;

  logic        rst_n;
  logic        req_valid;
  logic        req_write;
  logic [31:0] req_va;
  logic [31:0] tbl_base;
  logic        req_ready;
  logic        mem_req_valid;
  logic [31:0] mem_req_addr;
  logic        mem_rsp_valid = 1'b0;
  logic [31:0] mem_rsp_data  = 32'h0;
  logic        done;
  logic [31:0] pa;
  logic [1:0]  size;
  logic        resp_write;
  logic        fault;
  logic        fault_level;
  logic [31:0] fault_addr;

  pt_walker uut (
    .clk_i          (clk),
    .rst_ni         (rst_n),
    .req_valid_i    (req_valid),
    .req_va_i       (req_va),
    .req_write_i    (req_write),
    .tbl_base_i     (tbl_base),
    .req_ready_o    (req_ready),
    .mem_req_valid_o(mem_req_valid),
    .mem_req_addr_o (mem_req_addr),
    .mem_rsp_valid_i(mem_rsp_valid),
    .mem_rsp_data_i (mem_rsp_data),
    .done_o         (done),
    .pa_o           (pa),
    .size_o         (size),
    .resp_write_o   (resp_write),
    .fault_o        (fault),
    .fault_level_o  (fault_level),
    .fault_addr_o   (fault_addr)
  );

  logic [31:0] mem [logic [31:0]];
  int          lat = 1;
  int          cnt = 0;
  int          nreq = 0;
  int          done_cyc = 0;
  int          fault_cyc = 0;
  logic [31:0] req_log [4];
  logic [31:0] pend_a = 32'h0;
  bit          stray = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  int cycles   = 0;

  bit          r_seen;
  bit          r_done;
  bit          r_fault;
  bit          r_lvl;
  bit          r_wr;
  logic [31:0] r_pa;
  logic [31:0] r_faddr;
  logic [1:0]  r_size;

  // Sparse memory with a programmable read latency; absent words read as 0
  always @(negedge clk) begin
    mem_rsp_valid = 1'b0;
    if (stray) begin
      mem_rsp_valid = 1'b1;
      mem_rsp_data  = 32'h0000_0002;
      stray = 1'b0;
    end
    if (cnt > 0) begin
      cnt = cnt - 1;
      if (cnt == 0) begin
        mem_rsp_valid = 1'b1;
        mem_rsp_data  = mem.exists(pend_a) ? mem[pend_a] : 32'h0;
      end
    end
    if (mem_req_valid) begin
      if (nreq < 4) req_log[nreq] = mem_req_addr;
      nreq   = nreq + 1;
      pend_a = mem_req_addr;
      cnt    = lat;
    end
    if (done)  done_cyc  = done_cyc + 1;
    if (fault) fault_cyc = fault_cyc + 1;
  end

  always @(posedge clk) begin
    cycles = cycles + 1;
    if (cycles > 100000) begin
      n_fail = n_fail + 1;
      $display("FAIL R9 watchdog: actual %0d cycles expected completion", cycles);
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

  task automatic chk(input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    n_checks = n_checks + 1;
    if (act !== exp) begin
      n_fail = n_fail + 1;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic walk(input logic [31:0] va, input logic wr,
                      input logic [31:0] base, input int l, input bit poke);
    int waited;
    @(negedge clk);
    lat = l; nreq = 0; done_cyc = 0; fault_cyc = 0;
    req_va = va; req_write = wr; tbl_base = base; req_valid = 1'b1;
    @(negedge clk);
    req_valid = 1'b0;
    if (poke) begin
      tbl_base  = 32'hDEAD_0000;
      req_va    = 32'hFFFF_FFFF;
      req_write = ~wr;
      req_valid = 1'b1;
    end
    r_seen = 1'b0;
    waited = 0;
    while (!r_seen && waited < 200) begin
      if (done || fault) begin
        r_seen  = 1'b1;
        r_done  = done;
        r_fault = fault;
        r_lvl   = fault_level;
        r_wr    = resp_write;
        r_pa    = pa;
        r_faddr = fault_addr;
        r_size  = size;
        req_valid = 1'b0;
      end else begin
        @(negedge clk);
        waited = waited + 1;
      end
    end
    req_valid = 1'b0;
    chk("R9", "walk completed", 32'(r_seen), 32'd1);
    repeat (3) @(negedge clk);
  endtask

  task automatic t_reset;
    chk("R1", "ready after reset", 32'(req_ready), 32'd1);
    chk("R1", "done after reset", 32'(done), 32'd0);
    chk("R1", "fault after reset", 32'(fault), 32'd0);
    chk("R1", "mem req after reset", 32'(mem_req_valid), 32'd0);
  endtask

  task automatic t_section;
    mem[32'h0001_048C] = 32'hABC0_0002;
    walk(32'h1234_5678, 1'b1, 32'h0001_0000, 1, 1'b0);
    chk("R2", "L1 fetch address", req_log[0], 32'h0001_048C);
    chk("R3", "single fetch", 32'(nreq), 32'd1);
    chk("R3", "done", 32'(r_done), 32'd1);
    chk("R3", "section pa", r_pa, 32'hABC4_5678);
    chk("R3", "section size", 32'(r_size), 32'd3);
    chk("R11", "write flag", 32'(r_wr), 32'd1);
    chk("R9", "one done pulse", 32'(done_cyc), 32'd1);
    chk("R9", "no fault pulse", 32'(fault_cyc), 32'd0);
    walk(32'h123F_FFFF, 1'b0, 32'h0001_0000, 3, 1'b0);
    chk("R3", "section pa top offset", r_pa, 32'hABCF_FFFF);
    chk("R11", "read flag", 32'(r_wr), 32'd0);
  endtask

  task automatic t_l1_fault;
    walk(32'h0050_0000, 1'b0, 32'h0001_0000, 2, 1'b0);
    chk("R2", "L1 fetch address", req_log[0], 32'h0001_0014);
    chk("R4", "fault type 0", 32'(r_fault), 32'd1);
    chk("R4", "fault level", 32'(r_lvl), 32'd0);
    chk("R4", "fault addr", r_faddr, 32'h0050_0000);
    chk("R4", "no L2 fetch", 32'(nreq), 32'd1);
    chk("R9", "one fault pulse", 32'(fault_cyc), 32'd1);
    chk("R9", "no done pulse", 32'(done_cyc), 32'd0);
    mem[32'h0001_0018] = 32'h1234_5673;
    walk(32'h0060_0123, 1'b1, 32'h0001_0000, 1, 1'b0);
    chk("R4", "fault type 3", 32'(r_fault), 32'd1);
    chk("R4", "fault level type 3", 32'(r_lvl), 32'd0);
    chk("R4", "fault addr type 3", r_faddr, 32'h0060_0123);
  endtask

  task automatic t_small;
    mem[32'h0002_1000] = 32'h0008_07FD;
    mem[32'h0008_040C] = 32'h5555_6002;
    mem[32'h0008_0500] = 32'h7777_7FFF;
    walk(32'h4000_3ABC, 1'b0, 32'h0002_0000, 1, 1'b0);
    chk("R5", "two fetches", 32'(nreq), 32'd2);
    chk("R2", "L1 fetch address", req_log[0], 32'h0002_1000);
    chk("R5", "L2 fetch address masked", req_log[1], 32'h0008_040C);
    chk("R7", "small pa", r_pa, 32'h5555_6ABC);
    chk("R7", "small size", 32'(r_size), 32'd1);
    walk(32'h4004_0DEF, 1'b0, 32'h0002_0000, 3, 1'b0);
    chk("R5", "L2 fetch address idx 0x40", req_log[1], 32'h0008_0500);
    chk("R7", "small pa type 3", r_pa, 32'h7777_7DEF);
    chk("R7", "small size type 3", 32'(r_size), 32'd1);
  endtask

  task automatic t_large;
    mem[32'h0008_0448] = 32'h9876_5431;
    walk(32'h4001_2345, 1'b1, 32'h0002_0000, 4, 1'b0);
    chk("R5", "L2 fetch address", req_log[1], 32'h0008_0448);
    chk("R6", "large done", 32'(r_done), 32'd1);
    chk("R6", "large pa", r_pa, 32'h9876_2345);
    chk("R6", "large size", 32'(r_size), 32'd2);
  endtask

  task automatic t_l2_fault;
    walk(32'h4005_5000, 1'b0, 32'h0002_0000, 2, 1'b0);
    chk("R8", "L2 fetch address", req_log[1], 32'h0008_0554);
    chk("R8", "L2 fault", 32'(r_fault), 32'd1);
    chk("R8", "fault level", 32'(r_lvl), 32'd1);
    chk("R8", "fault addr", r_faddr, 32'h4005_5000);
    chk("R9", "one fault pulse", 32'(fault_cyc), 32'd1);
  endtask

  task automatic t_base_latch;
    walk(32'h4000_3ABC, 1'b1, 32'h0002_0000, 5, 1'b1);
    chk("R10", "L1 address from captured base", req_log[0], 32'h0002_1000);
    chk("R10", "pa unaffected by base change", r_pa, 32'h5555_6ABC);
    chk("R11", "flag captured at accept", 32'(r_wr), 32'd1);
    chk("R9", "busy request ignored: fetches", 32'(nreq), 32'd2);
    chk("R9", "busy request ignored: pulses", 32'(done_cyc + fault_cyc), 32'd1);
  endtask

  task automatic t_stray;
    @(negedge clk);
    nreq = 0; done_cyc = 0; fault_cyc = 0;
    stray = 1'b1;
    repeat (4) @(negedge clk);
    chk("R12", "stray response: done", 32'(done_cyc), 32'd0);
    chk("R12", "stray response: fault", 32'(fault_cyc), 32'd0);
    chk("R12", "stray response: fetch", 32'(nreq), 32'd0);
    chk("R12", "stray response: ready", 32'(req_ready), 32'd1);
  endtask

  initial begin
    rst_n     = 1'b0;
    req_valid = 1'b0;
    req_write = 1'b0;
    req_va    = 32'h0;
    tbl_base  = 32'h0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset();
    t_section();
    t_l1_fault();
    t_small();
    t_large();
    t_l2_fault();
    t_base_latch();
    t_stray();
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

endmodule